// File: doc/BRIEF.md
# Secure-partition memory protection controller

This block stands between one bus master and one downstream memory and decides, transaction by transaction, whether an access may reach the memory. The memory is cut into equal, aligned blocks whose size is a power of two. A table holds one bit per block, and that bit marks the block as belonging to the secure or to the non-secure world. An access whose security attribute matches the owner of its block is forwarded unchanged. Any other access is diverted to an internal sink: a diverted read completes with zero data, a diverted write is dropped, and neither one is seen by the memory.

Software programs the table and reads its geometry and fault information through a 4 KB register window on a simple valid/ready bus with byte enables. Only secure masters may see the control registers. Non-secure masters see only a bank of fixed identification bytes at the top of the window. A rejected access latches a fault flag together with the address and attributes of the first rejection, and the flag drives an interrupt through an enable bit.

Top module: `secpart_mpc`

## Requirements
- R1: After reset every table bit is 0, so every block is secure. The fault flag, the interrupt enable, the control word and the table index all read zero, and `irq`, `cfg_rsp_valid` and `up_rvalid` are low.
- R2: The block number is `up_addr >> BLK_LOG2`. Its table word is block/32 and its bit is block%32. A bit value of 1 marks a non-secure block. An access passes only when its effective security differs from the bit: secure accesses pass on blocks whose bit is 0, and non-secure accesses pass on blocks whose bit is 1. A passed access reaches the downstream port, and passed reads return the downstream data.
- R3: A rejected read is accepted at once and returns zero data one cycle after acceptance. A rejected write never raises `dn_valid`, so the memory contents stay unchanged.
- R4: An upstream access with `up_attr_valid` low is treated as secure, whatever `up_secure` holds.
- R5: Twelve read-only identification registers occupy byte offsets 0xFD0 + 4n for n = 0..11. They read 0x04, 0x00, 0x00, 0x00, 0x60, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, to secure and non-secure masters alike, and writes to them are ignored.
- R6: A non-secure access to any offset below 0xFD0 reads zero, has no effect when it is a write, and still receives its response.
- R7: Offset 0x10 reads the number of table words (ceil(blocks/32), 8 by default). Offset 0x14 reads BLK_LOG2 − 5 (3 by default).
- R8: The index register at 0x18 selects the table word that offset 0x1C reads and writes. The index register keeps only its low IDX_W bits (3 by default), so writing 9 reads back as 1.
- R9: Register writes update only the byte lanes whose `cfg_be` bit is set. Read data is zero in every lane whose `cfg_be` bit is clear.
- R10: The control word at 0x00 is a 32-bit read/write register. The clear (0x24) and set (0x34) registers read zero, and so does every unmapped offset.
- R11: A rejection sets the fault flag at 0x20 bit 0. If the flag was clear, the rejection also records the address in 0x2C and its attributes in 0x30 (bit 0 = write, bit 1 = effective secure). Later rejections leave the record unchanged until the flag is cleared. A rejection in the same cycle as a clear leaves the flag set.
- R12: Writing 1 to bit 0 of 0x24 clears the fault flag, and writing 1 to bit 0 of 0x34 sets it without changing the record. `irq` equals the flag ANDed with bit 0 of the enable register at 0x28.
- R13: `cfg_ready` is always high. Every accepted register request gets `cfg_rsp_valid` exactly one cycle later, with zero data for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Register request valid |
| cfg_ready | output | 1 | Register request accepted (always high) |
| cfg_write | input | 1 | 1 = register write |
| cfg_addr | input | 10 | Word address within the 4 KB window (byte address bits 11:2) |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Register write data |
| cfg_secure | input | 1 | Register request comes from a secure master |
| cfg_rsp_valid | output | 1 | Register response, one cycle after acceptance |
| cfg_rdata | output | 32 | Register read data |
| up_valid | input | 1 | Upstream access valid |
| up_ready | output | 1 | Upstream access accepted |
| up_write | input | 1 | 1 = upstream write |
| up_addr | input | MEM_LOG2 | Upstream byte address |
| up_wdata | input | DW | Upstream write data |
| up_secure | input | 1 | Secure attribute of the access |
| up_attr_valid | input | 1 | Security attribute present; 0 = treat as secure |
| up_rvalid | output | 1 | Upstream read data valid |
| up_rdata | output | DW | Upstream read data |
| dn_valid | output | 1 | Downstream access valid |
| dn_ready | input | 1 | Downstream accepts the access |
| dn_write | output | 1 | Downstream write |
| dn_addr | output | MEM_LOG2 | Downstream byte address |
| dn_wdata | output | DW | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | DW | Downstream read data |
| irq | output | 1 | Rejected-access interrupt |

## Verification
A corrupted table bit becomes visible at the next access to that block: a read that should pass returns zero instead of memory data, or a read that should be blocked returns memory data, both one cycle after acceptance, and the fault flag changes with it. A bad fault flag or record shows on `irq` in the cycle after the rejection or register write that caused it, and in the next read of 0x20, 0x2C or 0x30. A broken privilege check or lane mask shows on `cfg_rdata` in the response cycle, or in the read-back that follows an ignored write.

// File: rtl/secpart_mpc_pkg.sv
package secpart_mpc_pkg;

    // Word indices (byte offset / 4) within the register window
    localparam logic [9:0] W_CTRL   = 10'h000;
    localparam logic [9:0] W_BMAX   = 10'h004;
    localparam logic [9:0] W_BCFG   = 10'h005;
    localparam logic [9:0] W_BIDX   = 10'h006;
    localparam logic [9:0] W_BLUT   = 10'h007;
    localparam logic [9:0] W_ISTAT  = 10'h008;
    localparam logic [9:0] W_ICLR   = 10'h009;
    localparam logic [9:0] W_IEN    = 10'h00A;
    localparam logic [9:0] W_INFO1  = 10'h00B;
    localparam logic [9:0] W_INFO2  = 10'h00C;
    localparam logic [9:0] W_ISET   = 10'h00D;
    localparam logic [9:0] W_ID0    = 10'h3F4;

    typedef enum logic [3:0] {
        RS_NONE, RS_CTRL, RS_BMAX, RS_BCFG, RS_BIDX, RS_BLUT, RS_ISTAT,
        RS_ICLR, RS_IEN, RS_INFO1, RS_INFO2, RS_ISET, RS_ID
    } reg_sel_e;

    typedef enum logic [1:0] {
        GT_IDLE, GT_WAIT_DN, GT_BLK_RSP
    } gate_st_e;

    typedef struct packed {
        logic        write;
        logic        secure;
        logic [9:0]  word;
        logic [3:0]  be;
        logic [31:0] wdata;
    } cfg_req_t;

    typedef struct packed {
        logic [31:0] addr;
        logic        secure;
        logic        write;
    } rej_info_t;

    function automatic reg_sel_e decode_word(input logic [9:0] w);
        case (w)
            W_CTRL:  return RS_CTRL;
            W_BMAX:  return RS_BMAX;
            W_BCFG:  return RS_BCFG;
            W_BIDX:  return RS_BIDX;
            W_BLUT:  return RS_BLUT;
            W_ISTAT: return RS_ISTAT;
            W_ICLR:  return RS_ICLR;
            W_IEN:   return RS_IEN;
            W_INFO1: return RS_INFO1;
            W_INFO2: return RS_INFO2;
            W_ISET:  return RS_ISET;
            default: return (w >= W_ID0) ? RS_ID : RS_NONE;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] n);
        case (n)
            4'd0:  return 8'h04;
            4'd4:  return 8'h60;
            4'd5:  return 8'hB8;
            4'd6:  return 8'h1B;
            4'd8:  return 8'h0D;
            4'd9:  return 8'hF0;
            4'd10: return 8'h05;
            4'd11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] merge_lanes(input logic [31:0] old,
                                                input logic [31:0] nw,
                                                input logic [3:0]  be);
        return (old & ~lane_mask(be)) | (nw & lane_mask(be));
    endfunction

endpackage

// File: rtl/mpc_lut.sv
module mpc_lut
    import secpart_mpc_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [3:0]       wbe,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [4:0]       lk_bit,
    output logic             lk_ns
);

    logic [31:0] tbl_q [WORDS];
    logic        widx_ok;
    logic        ridx_ok;

    assign widx_ok = (32'(widx) < WORDS);
    assign ridx_ok = (32'(ridx) < WORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) tbl_q[w] <= '0;
        end else if (we && widx_ok) begin
            tbl_q[widx] <= merge_lanes(tbl_q[widx], wdata, wbe);
        end
    end

    assign rdata = ridx_ok ? tbl_q[ridx] : '0;
    assign lk_ns = tbl_q[lk_idx][lk_bit];

endmodule

// File: rtl/mpc_gate.sv
module mpc_gate
    import secpart_mpc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_write,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_wdata,
    input  logic          up_secure,
    input  logic          up_attr_valid,
    output logic          up_rvalid,
    output logic [DW-1:0] up_rdata,
    input  logic          lk_ns,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_write,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    input  logic          dn_rvalid,
    input  logic [DW-1:0] dn_rdata,
    output logic          rej_valid,
    output rej_info_t     rej_info
);

    gate_st_e state_q;
    logic     eff_sec;
    logic     allow;
    logic     idle;
    logic     accept;

    assign eff_sec  = up_secure | ~up_attr_valid;
    assign allow    = (eff_sec != lk_ns);
    assign idle     = (state_q == GT_IDLE);

    assign dn_valid = up_valid & idle & allow;
    assign dn_write = up_write;
    assign dn_addr  = up_addr;
    assign dn_wdata = up_wdata;

    assign up_ready = idle & (allow ? dn_ready : 1'b1);
    assign accept   = up_valid & up_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GT_IDLE;
        end else begin
            case (state_q)
                GT_IDLE:    if (accept && !up_write)
                                state_q <= allow ? GT_WAIT_DN : GT_BLK_RSP;
                GT_WAIT_DN: if (dn_rvalid) state_q <= GT_IDLE;
                default:    state_q <= GT_IDLE;
            endcase
        end
    end

    assign up_rvalid = ((state_q == GT_WAIT_DN) & dn_rvalid) | (state_q == GT_BLK_RSP);
    assign up_rdata  = (state_q == GT_WAIT_DN) ? dn_rdata : '0;

    assign rej_valid       = accept & ~allow;
    assign rej_info.addr   = 32'(up_addr);
    assign rej_info.secure = eff_sec;
    assign rej_info.write  = up_write;

    // R3: a rejected read answers with zero data in the next cycle
    a_r3_blocked_read_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && !allow && !up_write) |=> (up_rvalid && up_rdata == '0));

    // R2: an accepted passing read is waiting on the memory in the next cycle
    a_r2_pass_read_waits: assert property (@(posedge clk) disable iff (rst)
        (accept && allow && !up_write) |=> (state_q == GT_WAIT_DN));

endmodule

// File: rtl/mpc_regs.sv
module mpc_regs
    import secpart_mpc_pkg::*;
#(
    parameter int WORDS    = 8,
    parameter int IDX_W    = 3,
    parameter int BLK_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  cfg_req_t         req,
    output logic             rsp_valid,
    output logic [31:0]      rsp_data,
    output logic             lut_we,
    output logic [IDX_W-1:0] lut_idx,
    output logic [31:0]      lut_wdata,
    output logic [3:0]       lut_be,
    input  logic [31:0]      lut_rdata,
    input  logic             rej_valid,
    input  rej_info_t        rej_info,
    output logic             irq
);

    reg_sel_e         sel;
    logic             priv;
    logic             swr;
    logic             clr_hit;
    logic             set_hit;
    logic [31:0]      ctrl_q;
    logic [IDX_W-1:0] idx_q;
    logic             ien_q;
    logic             stat_q;
    rej_info_t        info_q;
    logic [31:0]      rd_word;
    logic [31:0]      idx_merged;

    assign sel     = decode_word(req.word);
    assign priv    = req.secure | (sel == RS_ID);
    assign swr     = req_fire & req.write & req.secure;
    assign clr_hit = swr & (sel == RS_ICLR) & req.be[0] & req.wdata[0];
    assign set_hit = swr & (sel == RS_ISET) & req.be[0] & req.wdata[0];

    assign idx_merged = merge_lanes(32'(idx_q), req.wdata, req.be);

    assign lut_we    = swr & (sel == RS_BLUT);
    assign lut_idx   = idx_q;
    assign lut_wdata = req.wdata;
    assign lut_be    = req.be;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            idx_q  <= '0;
            ien_q  <= 1'b0;
        end else if (swr) begin
            if (sel == RS_CTRL) ctrl_q <= merge_lanes(ctrl_q, req.wdata, req.be);
            if (sel == RS_BIDX) idx_q  <= idx_merged[IDX_W-1:0];
            if (sel == RS_IEN && req.be[0]) ien_q <= req.wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
            info_q <= '0;
        end else begin
            if (rej_valid || set_hit) stat_q <= 1'b1;
            else if (clr_hit)         stat_q <= 1'b0;
            if (rej_valid && !stat_q) info_q <= rej_info;
        end
    end

    always_comb begin
        case (sel)
            RS_CTRL:  rd_word = ctrl_q;
            RS_BMAX:  rd_word = 32'(WORDS);
            RS_BCFG:  rd_word = 32'(BLK_LOG2 - 5);
            RS_BIDX:  rd_word = 32'(idx_q);
            RS_BLUT:  rd_word = lut_rdata;
            RS_ISTAT: rd_word = {31'b0, stat_q};
            RS_IEN:   rd_word = {31'b0, ien_q};
            RS_INFO1: rd_word = info_q.addr;
            RS_INFO2: rd_word = {30'b0, info_q.secure, info_q.write};
            RS_ID:    rd_word = {24'b0, id_byte(4'(req.word - W_ID0))};
            default:  rd_word = '0;
        endcase
        if (!priv) rd_word = '0;
        rd_word = rd_word & lane_mask(req.be);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_fire;
            rsp_data  <= (req_fire && !req.write) ? rd_word : '0;
        end
    end

    assign irq = stat_q & ien_q;

    // R6: a non-secure write below the ID bank changes no register
    a_r6_ns_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (req_fire && req.write && !req.secure && sel != RS_ID)
        |=> ($stable(ctrl_q) && $stable(idx_q) && $stable(ien_q)));

    // R11: a rejection leaves the fault flag set, even against a clear
    a_r11_reject_latches: assert property (@(posedge clk) disable iff (rst)
        rej_valid |=> stat_q);

    // R11: the first fault record is held while the flag stays uncleared
    a_r11_record_held: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr_hit) |=> $stable(info_q));

    // R13: every accepted request is answered in the next cycle
    a_r13_rsp_next: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> rsp_valid);

endmodule

// File: rtl/secpart_mpc.sv
module secpart_mpc
    import secpart_mpc_pkg::*;
#(
    parameter int MEM_LOG2 = 16,
    parameter int BLK_LOG2 = 8,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_valid,
    output logic                cfg_ready,
    input  logic                cfg_write,
    input  logic [11:2]         cfg_addr,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    input  logic                cfg_secure,
    output logic                cfg_rsp_valid,
    output logic [31:0]         cfg_rdata,
    input  logic                up_valid,
    output logic                up_ready,
    input  logic                up_write,
    input  logic [MEM_LOG2-1:0] up_addr,
    input  logic [DW-1:0]       up_wdata,
    input  logic                up_secure,
    input  logic                up_attr_valid,
    output logic                up_rvalid,
    output logic [DW-1:0]       up_rdata,
    output logic                dn_valid,
    input  logic                dn_ready,
    output logic                dn_write,
    output logic [MEM_LOG2-1:0] dn_addr,
    output logic [DW-1:0]       dn_wdata,
    input  logic                dn_rvalid,
    input  logic [DW-1:0]       dn_rdata,
    output logic                irq
);

    localparam int BW     = MEM_LOG2 - BLK_LOG2;
    localparam int BLOCKS = 1 << BW;
    localparam int WORDS  = (BLOCKS + 31) / 32;
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

    cfg_req_t         req;
    logic             req_fire;
    logic [BW-1:0]    blk_num;
    logic [IDX_W-1:0] lk_idx;
    logic [4:0]       lk_bit;
    logic             lk_ns;
    logic             lut_we;
    logic [IDX_W-1:0] lut_idx;
    logic [31:0]      lut_wdata;
    logic [3:0]       lut_be;
    logic [31:0]      lut_rdata;
    logic             rej_valid;
    rej_info_t        rej_info;

    assign cfg_ready    = 1'b1;
    assign req_fire     = cfg_valid & cfg_ready;
    assign req.write    = cfg_write;
    assign req.secure   = cfg_secure;
    assign req.word     = cfg_addr;
    assign req.be       = cfg_be;
    assign req.wdata    = cfg_wdata;

    assign blk_num = up_addr[MEM_LOG2-1:BLK_LOG2];

    if (BW > 5) begin : g_multi_word
        assign lk_idx = blk_num[BW-1:5];
        assign lk_bit = blk_num[4:0];
    end else begin : g_single_word
        assign lk_idx = '0;
        assign lk_bit = 5'(blk_num);
    end

    mpc_lut #(.WORDS(WORDS), .IDX_W(IDX_W)) u_lut (
        .clk    (clk),
        .rst    (rst),
        .we     (lut_we),
        .widx   (lut_idx),
        .wdata  (lut_wdata),
        .wbe    (lut_be),
        .ridx   (lut_idx),
        .rdata  (lut_rdata),
        .lk_idx (lk_idx),
        .lk_bit (lk_bit),
        .lk_ns  (lk_ns)
    );

    mpc_gate #(.AW(MEM_LOG2), .DW(DW)) u_gate (
        .clk           (clk),
        .rst           (rst),
        .up_valid      (up_valid),
        .up_ready      (up_ready),
        .up_write      (up_write),
        .up_addr       (up_addr),
        .up_wdata      (up_wdata),
        .up_secure     (up_secure),
        .up_attr_valid (up_attr_valid),
        .up_rvalid     (up_rvalid),
        .up_rdata      (up_rdata),
        .lk_ns         (lk_ns),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_write      (dn_write),
        .dn_addr       (dn_addr),
        .dn_wdata      (dn_wdata),
        .dn_rvalid     (dn_rvalid),
        .dn_rdata      (dn_rdata),
        .rej_valid     (rej_valid),
        .rej_info      (rej_info)
    );

    mpc_regs #(.WORDS(WORDS), .IDX_W(IDX_W), .BLK_LOG2(BLK_LOG2)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req       (req),
        .rsp_valid (cfg_rsp_valid),
        .rsp_data  (cfg_rdata),
        .lut_we    (lut_we),
        .lut_idx   (lut_idx),
        .lut_wdata (lut_wdata),
        .lut_be    (lut_be),
        .lut_rdata (lut_rdata),
        .rej_valid (rej_valid),
        .rej_info  (rej_info),
        .irq       (irq)
    );

endmodule

// File: tb/tb_secpart_mpc.sv
`timescale 1ns/1ps
module tb_secpart_mpc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic        cfg_ready;
    logic        cfg_write = 1'b0;
    logic [11:2] cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_secure = 1'b0;
    logic        cfg_rsp_valid;
    logic [31:0] cfg_rdata;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic        up_write = 1'b0;
    logic [15:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic        up_secure = 1'b0;
    logic        up_attr_valid = 1'b1;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_valid;
    logic        dn_ready = 1'b1;
    logic        dn_write;
    logic [15:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_rvalid;
    logic [31:0] dn_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int dn_wr_count;
    logic [31:0] mem [64];

    logic [31:0] cfg_exp_q [$];
    string       cfg_tag_q [$];
    logic [31:0] up_exp_q [$];
    string       up_tag_q [$];

    always #4 clk = ~clk;

    secpart_mpc dut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_secure(cfg_secure), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata),
        .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_secure(up_secure),
        .up_attr_valid(up_attr_valid), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid),
        .dn_rdata(dn_rdata), .irq(irq)
    );

    // Downstream memory model: one-cycle read latency
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC000_0000 + 32'(i);
        dn_wr_count = 0;
        dn_rvalid = 1'b0;
        dn_rdata = '0;
    end

    always @(posedge clk) begin
        dn_rvalid <= 1'b0;
        if (dn_valid && dn_ready) begin
            if (dn_write) begin
                mem[dn_addr[7:2]] <= dn_wdata;
                dn_wr_count <= dn_wr_count + 1;
            end else begin
                dn_rvalid <= 1'b1;
                dn_rdata  <= mem[dn_addr[7:2]];
            end
        end
    end

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cfg_rsp_valid) begin
            if (cfg_exp_q.size() == 0) check_eq(cfg_rdata, 32'hx, "R13 unexpected cfg response");
            else check_eq(cfg_rdata, cfg_exp_q.pop_front(), cfg_tag_q.pop_front());
        end
        if (!rst && up_rvalid) begin
            if (up_exp_q.size() == 0) check_eq(up_rdata, 32'hx, "R3 unexpected read response");
            else check_eq(up_rdata, up_exp_q.pop_front(), up_tag_q.pop_front());
        end
    end

    task automatic cfg_xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                            input logic [3:0] be, input bit sec,
                            input logic [31:0] exp, input string tag);
        cfg_exp_q.push_back(exp);
        cfg_tag_q.push_back(tag);
        @(negedge clk);
        cfg_valid  = 1'b1;
        cfg_write  = wr;
        cfg_addr   = a[11:2];
        cfg_wdata  = d;
        cfg_be     = be;
        cfg_secure = sec;
        @(negedge clk);
        cfg_valid  = 1'b0;
    endtask

    task automatic cfg_rd(input logic [11:0] a, input bit sec, input logic [31:0] exp, input string tag);
        cfg_xfer(1'b0, a, 32'h0, 4'hF, sec, exp, tag);
    endtask

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d, input bit sec, input string tag);
        cfg_xfer(1'b1, a, d, 4'hF, sec, 32'h0, tag);
    endtask

    task automatic up_xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                           input bit sec, input bit known,
                           input logic [31:0] exp, input string tag);
        if (!wr) begin
            up_exp_q.push_back(exp);
            up_tag_q.push_back(tag);
        end
        @(negedge clk);
        up_valid      = 1'b1;
        up_write      = wr;
        up_addr       = a;
        up_wdata      = d;
        up_secure     = sec;
        up_attr_valid = known;
        @(negedge clk);
        up_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq(32'(irq), 0, "R1 irq low in reset");
        check_eq(32'(cfg_rsp_valid), 0, "R1 no cfg response in reset");
        check_eq(32'(up_rvalid), 0, "R1 no read response in reset");
        rst = 1'b0;
        check_eq(32'(cfg_ready), 1, "R13 cfg_ready high");
        cfg_rd(12'h018, 1, 0, "R1 index zero");
        cfg_rd(12'h01C, 1, 0, "R1 table word 0 all secure");
        cfg_rd(12'h020, 1, 0, "R1 fault flag clear");
        cfg_rd(12'h000, 1, 0, "R1 control zero");

        // identification bank
        cfg_rd(12'hFD0, 1, 32'h04, "R5 id 0xFD0");
        cfg_rd(12'hFE0, 0, 32'h60, "R5 id 0xFE0 non-secure");
        cfg_rd(12'hFE8, 1, 32'h1B, "R5 id 0xFE8");
        cfg_rd(12'hFF4, 0, 32'hF0, "R5 id 0xFF4 non-secure");
        cfg_rd(12'hFFC, 1, 32'hB1, "R5 id 0xFFC");
        cfg_wr(12'hFD0, 32'hFF, 1, "R5 id write response");
        cfg_rd(12'hFD0, 1, 32'h04, "R5 id write ignored");

        // geometry
        cfg_rd(12'h010, 1, 8, "R7 table words");
        cfg_rd(12'h014, 1, 3, "R7 block size code");

        // non-secure hiding
        cfg_rd(12'h010, 0, 0, "R6 non-secure read hidden");
        cfg_wr(12'h018, 5, 0, "R6 non-secure write response");
        cfg_rd(12'h018, 1, 0, "R6 non-secure index write dropped");
        cfg_wr(12'h000, 32'h1234_5678, 1, "R10 control write");
        cfg_rd(12'h000, 1, 32'h1234_5678, "R10 control read back");
        cfg_wr(12'h000, 32'h0, 0, "R6 non-secure control write");
        cfg_rd(12'h000, 1, 32'h1234_5678, "R6 control unchanged");
        cfg_rd(12'h024, 1, 0, "R10 clear register reads zero");
        cfg_rd(12'h034, 1, 0, "R10 set register reads zero");
        cfg_rd(12'h100, 1, 0, "R10 unmapped reads zero");

        // indexed table access
        cfg_wr(12'h018, 9, 1, "R8 index write");
        cfg_rd(12'h018, 1, 1, "R8 index keeps low bits");
        cfg_wr(12'h01C, 3, 1, "R8 table word 1 write");
        cfg_rd(12'h01C, 1, 3, "R8 table word 1 read");
        cfg_wr(12'h018, 0, 1, "R8 index 0");
        cfg_rd(12'h01C, 1, 0, "R8 word 0 untouched");
        cfg_wr(12'h018, 1, 1, "R8 index 1");
        cfg_xfer(1'b1, 12'h01C, 32'h0000_AA00, 4'b0010, 1, 0, "R9 lane write");
        cfg_rd(12'h01C, 1, 32'h0000_AA03, "R9 lane merge");
        cfg_xfer(1'b0, 12'h01C, 32'h0, 4'b0010, 1, 32'h0000_AA00, "R9 lane read");
        cfg_wr(12'h01C, 3, 1, "R8 restore word 1");

        // pass / block decision: blocks 32,33 (0x2000-0x21FF) are non-secure
        up_xfer(0, 16'h0040, 0, 1, 1, 32'hC000_0010, "R2 secure read of secure block");
        up_xfer(0, 16'h2004, 0, 0, 1, 32'hC000_0001, "R2 non-secure read of non-secure block");
        up_xfer(0, 16'h0040, 0, 0, 1, 32'h0, "R3 non-secure read blocked");
        check_eq(32'(irq), 0, "R12 irq masked when disabled");
        cfg_rd(12'h020, 1, 1, "R11 flag set");
        cfg_rd(12'h02C, 1, 32'h0040, "R11 address recorded");
        cfg_rd(12'h030, 1, 0, "R11 attributes recorded");
        cfg_wr(12'h024, 1, 1, "R12 clear");
        cfg_rd(12'h020, 1, 0, "R12 flag cleared");
        cfg_wr(12'h028, 1, 1, "R12 enable");

        up_xfer(0, 16'h2004, 0, 1, 1, 32'h0, "R3 secure read of non-secure block blocked");
        check_eq(32'(irq), 1, "R12 irq raised");
        up_xfer(1, 16'h0080, 32'h55, 0, 1, 0, "R3 blocked write");
        check_eq(32'(dn_wr_count), 0, "R3 blocked write never reaches memory");
        cfg_rd(12'h02C, 1, 32'h2004, "R11 first address held");
        cfg_rd(12'h030, 1, 2, "R11 first attributes held");
        up_xfer(0, 16'h0080, 0, 1, 1, 32'hC000_0020, "R3 memory unchanged after blocked write");

        cfg_wr(12'h024, 1, 1, "R12 clear");
        check_eq(32'(irq), 0, "R12 irq drops after clear");
        cfg_wr(12'h034, 1, 1, "R12 set");
        check_eq(32'(irq), 1, "R12 irq after set");
        cfg_rd(12'h02C, 1, 32'h2004, "R12 set keeps record");
        cfg_wr(12'h028, 0, 1, "R12 disable");
        check_eq(32'(irq), 0, "R12 irq follows enable");
        cfg_wr(12'h024, 1, 1, "R12 clear");

        // missing attribute counts as secure
        up_xfer(0, 16'h0040, 0, 0, 0, 32'hC000_0010, "R4 unknown attribute passes on secure block");
        up_xfer(0, 16'h2004, 0, 0, 0, 32'h0, "R4 unknown attribute blocked on non-secure block");
        cfg_rd(12'h030, 1, 2, "R4 recorded as secure");
        cfg_wr(12'h024, 1, 1, "R12 clear");

        // passed writes
        up_xfer(1, 16'h0044, 32'hDEAD_BEEF, 1, 1, 0, "R2 secure write");
        check_eq(32'(dn_wr_count), 1, "R2 passed write reaches memory");
        up_xfer(0, 16'h0044, 0, 1, 1, 32'hDEAD_BEEF, "R2 written data read back");
        up_xfer(1, 16'h2008, 32'h0BAD_F00D, 0, 1, 0, "R2 non-secure write");
        check_eq(32'(dn_wr_count), 2, "R2 non-secure write reaches memory");
        cfg_rd(12'h020, 1, 0, "R11 no fault from passed accesses");

        @(negedge clk);
        check_eq(32'(cfg_exp_q.size()), 0, "R13 every cfg request answered");
        check_eq(32'(up_exp_q.size()), 0, "R3 every read answered");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule